// File: doc/BRIEF.md
# Address-Match Breakpoint Unit

This block watches the CPU address bus and raises a break interrupt request when the address on the bus equals a 16-bit breakpoint held in two byte-wide registers. A control register carries an enable bit and an active bit. Software can also force a break by writing the active bit to 1. Once a break is taken, it stays pending until software writes the active bit back to 0.

The unit takes two low-power inputs from the CPU. While the stop input is high, address matching is switched off, but every register keeps its contents. While the wait input is high, matching continues. A separate wake flag records that a break occurred during wait, so the break handler can tell that the break is what ended the wait.

All registers sit behind one byte-wide port. That port has a select, a write strobe, write data and a combinational read path. The reset input is asynchronous and active low, and its release is synchronised to the clock inside the block.

Top module: `addr_break_unit`

## Requirements
- R1: After reset, every register reads 0x00, `brk_irq` is 0 and `brk_wait` is 0.
- R2: Register select 1 is the breakpoint high byte and select 2 is the breakpoint low byte. A write stores `reg_wdata`, and a read returns the stored byte.
- R3: When control bit 7 (enable) is 1 and `cpu_addr` equals {high byte, low byte}, control bit 6 (active) is set on the next clock edge, and `brk_irq` is 1 from then on.
- R4: When the enable bit is 0, an address match does not set the active bit.
- R5: A write to select 0 with bit 6 set to 1 sets the active bit and `brk_irq`, whether or not an address match exists.
- R6: The active bit stays set until a write to select 0 with bit 6 equal to 0 clears it. If an enabled match occurs in the same cycle as that write, the match wins and the bit stays set.
- R7: While `stop_mode` is 1, no address match sets the active bit. All register contents are unchanged across stop. Once `stop_mode` is 0 again, matching resumes.
- R8: A break taken while `wait_mode` is 1, whether from a match or from software, sets the wake flag. The wake flag is bit 0 of select 3 and also drives `brk_wait`. A break taken while `wait_mode` is 0 leaves the flag unchanged.
- R9: Writing select 3 with bit 0 equal to 0 clears the wake flag. Writing bit 0 equal to 1 has no effect.
- R10: Control bits 5 to 0 and select-3 bits 7 to 1 always read 0, whatever value is written to them.
- R11: A match on only one byte of the address, high or low, does not set the active bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 16 | CPU address bus being watched |
| wait_mode | input | 1 | CPU is in wait mode |
| stop_mode | input | 1 | CPU is in stop mode |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 control, 1 high byte, 2 low byte, 3 wake status |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data for the selected register (combinational) |
| brk_irq | output | 1 | Break interrupt request; follows the active bit |
| brk_wait | output | 1 | Wake flag: a break occurred during wait |

## Verification
A wrong breakpoint byte or a stuck enable shows up as a missing or spurious `brk_irq` one clock after the address is presented. Because the active bit latches, that error persists until software clears it, so it is seen on the port at the next sample. A wake flag that is wrongly set or never cleared shows on `brk_wait` and in select 3 in the cycle after the offending event. Corruption during stop appears on the next read of the same register, or as a break that fails to arrive one cycle after stop ends.

// File: rtl/abu_pkg.sv
package abu_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 2 * BYTE_W;
  localparam int SEL_W  = 2;

  typedef enum logic [SEL_W-1:0] {
    SEL_CTRL = 2'd0,
    SEL_HI   = 2'd1,
    SEL_LO   = 2'd2,
    SEL_WST  = 2'd3
  } reg_sel_e;

  localparam int BIT_EN  = 7;
  localparam int BIT_ACT = 6;
  localparam int BIT_BW  = 0;
endpackage

// File: rtl/abu_rst_sync.sv
module abu_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= '0;
    else           sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_out = sync_q[STAGES-1];
endmodule

// File: rtl/abu_cmp.sv
module abu_cmp #(
  parameter int ADDR_W = 16,
  parameter int LANE_W = 8
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] bkpt,
  input  logic              enable,
  input  logic              stop_mode,
  output logic              hit
);
  localparam int NLANES = ADDR_W / LANE_W;

  logic [NLANES-1:0] lane_eq;

  for (genvar g = 0; g < NLANES; g++) begin : g_lane
    assign lane_eq[g] = (addr[g*LANE_W +: LANE_W] == bkpt[g*LANE_W +: LANE_W]);
  end

  // Comparator is gated off completely in stop mode.
  assign hit = enable & ~stop_mode & (&lane_eq);
endmodule

// File: rtl/abu_regs.sv
module abu_regs
  import abu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [SEL_W-1:0]  reg_sel,
  input  logic [BYTE_W-1:0] reg_wdata,
  input  logic              hit,
  input  logic              wait_mode,
  output logic [ADDR_W-1:0] bkpt,
  output logic              en,
  output logic              active,
  output logic              bwait,
  output logic [BYTE_W-1:0] reg_rdata
);
  logic [BYTE_W-1:0] hi_q, lo_q;
  logic              en_q, act_q, bw_q;
  logic              en_d, act_d, bw_d;
  logic              wr_ctrl, wr_hi, wr_lo, wr_wst;
  logic              brk_set;

  // Write decode, used as clock enables.
  always_comb begin
    wr_ctrl = reg_wr && (reg_sel == SEL_CTRL);
    wr_hi   = reg_wr && (reg_sel == SEL_HI);
    wr_lo   = reg_wr && (reg_sel == SEL_LO);
    wr_wst  = reg_wr && (reg_sel == SEL_WST);
  end

  // Next-state logic. A hardware set takes priority over a software clear.
  always_comb begin
    brk_set = hit | (wr_ctrl & reg_wdata[BIT_ACT]);
    en_d    = wr_ctrl ? reg_wdata[BIT_EN] : en_q;
    act_d   = brk_set | (act_q & ~wr_ctrl);
    bw_d    = (brk_set & wait_mode) | (bw_q & ~(wr_wst & ~reg_wdata[BIT_BW]));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q <= '0;
      lo_q <= '0;
    end else begin
      if (wr_hi) hi_q <= reg_wdata;
      if (wr_lo) lo_q <= reg_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      act_q <= 1'b0;
      bw_q  <= 1'b0;
    end else begin
      en_q  <= en_d;
      act_q <= act_d;
      bw_q  <= bw_d;
    end
  end

  // Read mux.
  always_comb begin
    reg_rdata = '0;
    unique case (reg_sel)
      SEL_CTRL: begin
        reg_rdata[BIT_EN]  = en_q;
        reg_rdata[BIT_ACT] = act_q;
      end
      SEL_HI:  reg_rdata = hi_q;
      SEL_LO:  reg_rdata = lo_q;
      SEL_WST: reg_rdata[BIT_BW] = bw_q;
      default: reg_rdata = '0;
    endcase
  end

  assign bkpt   = {hi_q, lo_q};
  assign en     = en_q;
  assign active = act_q;
  assign bwait  = bw_q;
endmodule

// File: rtl/addr_break_unit.sv
module addr_break_unit
  import abu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [15:0]       cpu_addr,
  input  logic              wait_mode,
  input  logic              stop_mode,
  input  logic              reg_wr,
  input  logic [1:0]        reg_sel,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  output logic              brk_irq,
  output logic              brk_wait
);
  logic              rst_sync_n;
  logic [ADDR_W-1:0] bkpt;
  logic              en;
  logic              active;
  logic              bwait;
  logic              hit;

  abu_rst_sync #(.STAGES(2)) u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_sync_n)
  );

  abu_cmp #(.ADDR_W(ADDR_W), .LANE_W(BYTE_W)) u_cmp (
    .addr      (cpu_addr),
    .bkpt      (bkpt),
    .enable    (en),
    .stop_mode (stop_mode),
    .hit       (hit)
  );

  abu_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .reg_wr    (reg_wr),
    .reg_sel   (reg_sel),
    .reg_wdata (reg_wdata),
    .hit       (hit),
    .wait_mode (wait_mode),
    .bkpt      (bkpt),
    .en        (en),
    .active    (active),
    .bwait     (bwait),
    .reg_rdata (reg_rdata)
  );

  assign brk_irq  = active;
  assign brk_wait = bwait;
endmodule

// File: rtl/abu_checker.sv
module abu_checker (
  input logic        clk,
  input logic        rst_sync_n,
  input logic [15:0] cpu_addr,
  input logic [15:0] bkpt,
  input logic        en,
  input logic        wait_mode,
  input logic        stop_mode,
  input logic        reg_wr,
  input logic [1:0]  reg_sel,
  input logic [7:0]  reg_wdata,
  input logic [7:0]  reg_rdata,
  input logic        brk_irq,
  input logic        brk_wait
);
  logic sw_set;
  logic ctrl_wr;
  assign ctrl_wr = reg_wr && (reg_sel == 2'd0);
  assign sw_set  = ctrl_wr && reg_wdata[6];

  a_r3_match_sets: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (en && !stop_mode && cpu_addr == bkpt) |=> brk_irq);

  a_r4_disabled_no_set: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!en && !brk_irq && !sw_set) |=> !brk_irq);

  a_r5_sw_set: assert property (@(posedge clk) disable iff (!rst_sync_n)
    sw_set |=> brk_irq);

  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (brk_irq && !ctrl_wr) |=> brk_irq);

  a_r7_stop_no_set: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (stop_mode && !brk_irq && !sw_set) |=> !brk_irq);

  a_r8_wait_flag: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wait_mode && sw_set) |=> brk_wait);

  a_r9_flag_hold: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (brk_wait && !(reg_wr && reg_sel == 2'd3)) |=> brk_wait);

  a_r10_ctrl_low_zero: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (reg_sel == 2'd0) |-> (reg_rdata[5:0] == 6'd0));
endmodule

bind addr_break_unit abu_checker u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .cpu_addr   (cpu_addr),
  .bkpt       (bkpt),
  .en         (en),
  .wait_mode  (wait_mode),
  .stop_mode  (stop_mode),
  .reg_wr     (reg_wr),
  .reg_sel    (reg_sel),
  .reg_wdata  (reg_wdata),
  .reg_rdata  (reg_rdata),
  .brk_irq    (brk_irq),
  .brk_wait   (brk_wait)
);

// File: tb/addr_break_unit_bench.sv
module addr_break_unit_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] cpu_addr;
  logic        wait_mode, stop_mode, reg_wr;
  logic [1:0]  reg_sel;
  logic [7:0]  reg_wdata;
  logic [7:0]  reg_rdata;
  logic        brk_irq, brk_wait;

  always #(CLK_PERIOD/2) clk = ~clk;

  addr_break_unit u_addr_break_unit (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .wait_mode(wait_mode),
    .stop_mode(stop_mode), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .brk_irq(brk_irq),
    .brk_wait(brk_wait)
  );

  // kind: 0 = reg_rdata, 1 = brk_irq, 2 = brk_wait
  typedef struct {
    int        kind;
    logic [7:0] exp;
    string     req;
  } item_t;

  item_t q[$];
  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  // Monitor: pops expected items and compares at the falling edge.
  initial begin
    forever begin
      @(negedge clk);
      if (q.size() > 0) begin
        item_t it;
        logic [7:0] got;
        it = q.pop_front();
        case (it.kind)
          0: got = reg_rdata;
          1: got = {7'd0, brk_irq};
          default: got = {7'd0, brk_wait};
        endcase
        n_cmp++;
        if (got !== it.exp) begin
          n_bad++;
          $display("FAIL %s kind=%0d actual=0x%02h expected=0x%02h", it.req, it.kind, got, it.exp);
        end
      end
    end
  end

  task automatic tick(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [7:0] d);
    @(posedge clk); #1;
    reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
    @(posedge clk); #1;
    reg_wr = 1'b0;
  endtask

  task automatic push(int kind, logic [7:0] exp, string req);
    item_t it;
    it.kind = kind; it.exp = exp; it.req = req;
    q.push_back(it);
    wait (q.size() == 0);
    #1;
  endtask

  task automatic expect_reg(input logic [1:0] sel, input logic [7:0] exp, input string req);
    reg_sel = sel;
    push(0, exp, req);
  endtask

  task automatic expect_irq(input logic e, input string req);
    push(1, {7'd0, e}, req);
  endtask

  task automatic expect_wait(input logic e, input string req);
    push(2, {7'd0, e}, req);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cpu_addr = 16'h0000; wait_mode = 1'b0; stop_mode = 1'b0;
    reg_wr = 1'b0; reg_sel = 2'd0; reg_wdata = 8'h00;
    tick(3);
    rst_n = 1'b1;
    tick(4);

    // R1 reset state
    expect_reg(2'd0, 8'h00, "R1 ctrl");
    expect_reg(2'd1, 8'h00, "R1 hi");
    expect_reg(2'd2, 8'h00, "R1 lo");
    expect_reg(2'd3, 8'h00, "R1 wst");
    expect_irq(1'b0, "R1 irq");
    expect_wait(1'b0, "R1 wait");

    // R2 breakpoint byte registers
    cpu_addr = 16'hFFFF;
    wr(2'd1, 8'h12);
    wr(2'd2, 8'h34);
    expect_reg(2'd1, 8'h12, "R2 hi");
    expect_reg(2'd2, 8'h34, "R2 lo");

    // R4 match with enable off
    cpu_addr = 16'h1234; tick(2);
    expect_irq(1'b0, "R4 disabled match");
    expect_reg(2'd0, 8'h00, "R4 ctrl");

    // R11 partial matches with enable on
    cpu_addr = 16'h1299;
    wr(2'd0, 8'h80);
    tick(1);
    expect_irq(1'b0, "R11 high byte only");
    cpu_addr = 16'h5634; tick(2);
    expect_irq(1'b0, "R11 low byte only");

    // R3 full match
    cpu_addr = 16'h1234; tick(1);
    cpu_addr = 16'h0000;
    expect_irq(1'b1, "R3 irq");
    expect_reg(2'd0, 8'hC0, "R3 ctrl");

    // R6 hold and clear, set wins over clear
    tick(3);
    expect_irq(1'b1, "R6 held");
    wr(2'd0, 8'h80);
    expect_irq(1'b0, "R6 cleared");
    expect_reg(2'd0, 8'h80, "R6 ctrl after clear");
    tick(1);
    cpu_addr = 16'h1234;
    wr(2'd0, 8'h80);
    cpu_addr = 16'h0000;
    expect_irq(1'b1, "R6 match beats clear");
    wr(2'd0, 8'h80);
    expect_irq(1'b0, "R6 clear again");

    // R5 software break with enable off
    wr(2'd0, 8'h40);
    expect_irq(1'b1, "R5 sw break");
    expect_reg(2'd0, 8'h40, "R5 ctrl");
    wr(2'd0, 8'h00);
    expect_irq(1'b0, "R5 clear");

    // R7 stop mode
    wr(2'd0, 8'h80);
    stop_mode = 1'b1;
    cpu_addr = 16'h1234; tick(3);
    expect_irq(1'b0, "R7 stop no match");
    expect_reg(2'd0, 8'h80, "R7 ctrl kept");
    expect_reg(2'd1, 8'h12, "R7 hi kept");
    expect_reg(2'd2, 8'h34, "R7 lo kept");
    stop_mode = 1'b0; tick(1);
    expect_irq(1'b1, "R7 resume after stop");
    cpu_addr = 16'h0000;
    wr(2'd0, 8'h80);
    expect_wait(1'b0, "R8 no wait flag outside wait");

    // R8 match during wait
    wait_mode = 1'b1;
    cpu_addr = 16'h1234; tick(1);
    cpu_addr = 16'h0000; wait_mode = 1'b0;
    expect_wait(1'b1, "R8 wait flag from match");
    expect_reg(2'd3, 8'h01, "R8 wst read");

    // R9 clear semantics
    wr(2'd3, 8'hFF);
    expect_reg(2'd3, 8'h01, "R9 write one ignored");
    wr(2'd3, 8'h00);
    expect_wait(1'b0, "R9 cleared");
    wr(2'd0, 8'h80);

    // R8 software break during wait
    wait_mode = 1'b1;
    wr(2'd0, 8'hC0);
    wait_mode = 1'b0;
    expect_wait(1'b1, "R8 wait flag from sw break");
    wr(2'd3, 8'h00);
    wr(2'd0, 8'h00);

    // R10 unimplemented bits
    wr(2'd0, 8'hBF);
    expect_reg(2'd0, 8'h80, "R10 ctrl low bits");
    wr(2'd3, 8'hFE);
    expect_reg(2'd3, 8'h00, "R10 wst high bits");

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule